// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Status Register

This block is one 16-bit host-visible register that steers a coprocessor and collects interrupt events from it and from the audio DMA engines around it. Four event sources each own a sticky status bit and a mask bit. The first audio stream, the accelerator, the coprocessor and the second audio stream each raise their status bit with a one-cycle event pulse. The host clears a status bit by writing 1 to it. The masked status bits are ORed into a single host interrupt line.

The same word also carries level-type controls that write straight through. These are a halt request, a host-to-coprocessor interrupt, and a boot-vector select: 1 starts the coprocessor from ROM at 0x8000, 0 starts it from RAM at 0x0000. It also carries a reset request that acts only as a trigger, and two read-only DMA busy flags. Each write therefore has different semantics from bit to bit. The read path is combinational from the stored state and the busy inputs. The interface is a plain register strobe rather than a stream, so there is no back-pressure: a write is taken in the cycle its strobe is high.

Top module: `cop_ctl_reg`

## Requirements
- R1: After reset, every stored bit is 0, so host_irq, cop_halt, cop_irq, cop_reset and boot_rom are 0, and reg_rdata shows only the busy inputs.
- R2: An event pulse on evt_pulse[i] sets its status bit from the next cycle on, and the bit stays set. The status bits sit at positions 3, 5, 7 and 12 of reg_rdata for i = 0, 1, 2, 3.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: When an event pulse and a write-1 clear of the same status bit fall in one cycle, the bit ends up set.
- R5: The mask bit for source i sits one position above its status bit (4, 6, 8, 13). It stores the written value, and host_irq is the OR over all sources of status AND mask.
- R6: Bit 2 stores the halt request. cop_halt follows it and it reads back.
- R7: Writing 1 to bit 0 drives cop_reset high for exactly the one cycle after the write. Bit 0 always reads 0.
- R8: Bit 11 stores the boot select and drives boot_rom: 1 selects the ROM vector 0x8000, 0 selects the RAM vector 0x0000. It reads back.
- R9: Bit 1 stores the host-to-coprocessor interrupt. cop_irq follows it as a level and it reads back.
- R10: Bit 10 reads cop_dma_busy and bit 9 reads aux_dma_busy. Bits 14 and 15 read 0. Writes to bits 9, 10, 14 and 15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register value |
| evt_pulse | input | 4 | One-cycle event pulses: 0 audio A, 1 accelerator, 2 coprocessor, 3 audio B |
| cop_dma_busy | input | 1 | Coprocessor-initiated DMA in progress |
| aux_dma_busy | input | 1 | Auxiliary-memory DMA in progress |
| host_irq | output | 1 | Combined masked interrupt to the host |
| cop_halt | output | 1 | Halt request to the coprocessor |
| cop_reset | output | 1 | One-cycle reset pulse to the coprocessor |
| boot_rom | output | 1 | Boot select: 1 ROM at 0x8000, 0 RAM at 0x0000 |
| cop_irq | output | 1 | Interrupt from the host to the coprocessor |

## Verification
The bench builds the block with its default of four event sources. With that setting, all 256 pairings of status pattern and mask pattern can be swept for the combined interrupt. The same holds for all 256 pairings of status pattern and clear pattern for write-one-to-clear, with and without events landing in the clearing cycle. The three level controls are swept over all eight combinations, each with a reset request, so that the single-cycle pulse and its zero readback are checked beside every control setting. The four busy-input combinations are checked while all-ones writes target the read-only and unused bits.

// File: rtl/cop_ctl_pkg.sv
package cop_ctl_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_SRC = 4;

  localparam int POS_RESET    = 0;
  localparam int POS_COP_IRQ  = 1;
  localparam int POS_HALT     = 2;
  localparam int POS_AUX_BUSY = 9;
  localparam int POS_DMA_BUSY = 10;
  localparam int POS_BOOT     = 11;

  // status bit position of event source i; its mask sits one above
  function automatic int stat_pos(input int i);
    case (i)
      0:       return 3;
      1:       return 5;
      2:       return 7;
      default: return 12;
    endcase
  endfunction

  function automatic int mask_pos(input int i);
    return stat_pos(i) + 1;
  endfunction

  typedef struct packed {
    logic halt;
    logic cop_irq;
    logic boot_rom;
  } ctl_t;
endpackage

// File: rtl/cop_irq_cell.sv
module cop_irq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_clr,
  input  logic wr_mask,
  input  logic evt,
  output logic stat,
  output logic mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
      mask <= 1'b0;
    end else begin
      // an arriving event outranks a same-cycle clear
      if (evt)
        stat <= 1'b1;
      else if (wr && wr_clr)
        stat <= 1'b0;
      if (wr)
        mask <= wr_mask;
    end
  end
endmodule

// File: rtl/cop_ctl_bits.sv
module cop_ctl_bits
  import cop_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_halt,
  input  logic wr_cop_irq,
  input  logic wr_boot,
  input  logic wr_reset,
  output ctl_t ctl,
  output logic rst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= wr && wr_reset;
      if (wr) begin
        ctl.halt     <= wr_halt;
        ctl.cop_irq  <= wr_cop_irq;
        ctl.boot_rom <= wr_boot;
      end
    end
  end
endmodule

// File: rtl/cop_irq_merge.sv
module cop_irq_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  output logic         irq
);
  assign irq = |(stat & mask);
endmodule

// File: rtl/cop_ctl_reg.sv
module cop_ctl_reg
  import cop_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic             cop_dma_busy,
  input  logic             aux_dma_busy,
  output logic             host_irq,
  output logic             cop_halt,
  output logic             cop_reset,
  output logic             boot_rom,
  output logic             cop_irq
);
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] mask;
  ctl_t               ctl;
  logic               wdata_unused;

  assign wdata_unused = ^{reg_wdata[15:14], reg_wdata[POS_DMA_BUSY], reg_wdata[POS_AUX_BUSY]};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    cop_irq_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wr_clr  (reg_wdata[stat_pos(i)]),
      .wr_mask (reg_wdata[mask_pos(i)]),
      .evt     (evt_pulse[i]),
      .stat    (stat[i]),
      .mask    (mask[i])
    );
  end

  cop_ctl_bits u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .wr_halt    (reg_wdata[POS_HALT]),
    .wr_cop_irq (reg_wdata[POS_COP_IRQ]),
    .wr_boot    (reg_wdata[POS_BOOT]),
    .wr_reset   (reg_wdata[POS_RESET]),
    .ctl        (ctl),
    .rst_pulse  (cop_reset)
  );

  cop_irq_merge #(.N(NUM_SRC)) u_merge (
    .stat (stat),
    .mask (mask),
    .irq  (host_irq)
  );

  assign cop_halt = ctl.halt;
  assign cop_irq  = ctl.cop_irq;
  assign boot_rom = ctl.boot_rom;

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[POS_COP_IRQ]  = ctl.cop_irq;
    reg_rdata[POS_HALT]     = ctl.halt;
    reg_rdata[POS_BOOT]     = ctl.boot_rom;
    reg_rdata[POS_DMA_BUSY] = cop_dma_busy;
    reg_rdata[POS_AUX_BUSY] = aux_dma_busy;
    for (int i = 0; i < NUM_SRC; i++) begin
      reg_rdata[stat_pos(i)] = stat[i];
      reg_rdata[mask_pos(i)] = mask[i];
    end
  end
endmodule

// File: rtl/cop_ctl_reg_chk.sv
module cop_ctl_reg_chk
  import cop_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic             cop_dma_busy,
  input logic             aux_dma_busy,
  input logic             host_irq,
  input logic             cop_halt,
  input logic             cop_reset,
  input logic             boot_rom,
  input logic             cop_irq
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R2 R4
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |=> reg_rdata[stat_pos(i)]);
    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[stat_pos(i)] && !evt_pulse[i]) |=> !reg_rdata[stat_pos(i)]);
    // R3
    w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[stat_pos(i)] && reg_rdata[stat_pos(i)]) |=> reg_rdata[stat_pos(i)]);
  end

  // R5
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == ((reg_rdata[3] & reg_rdata[4]) | (reg_rdata[5] & reg_rdata[6]) |
                 (reg_rdata[7] & reg_rdata[8]) | (reg_rdata[12] & reg_rdata[13])));
  // R6
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (cop_halt == $past(reg_wdata[POS_HALT])));
  // R7
  reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[POS_RESET]) |=> cop_reset);
  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_wdata[POS_RESET]) |=> !cop_reset);
  // R7
  reset_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[POS_RESET]);
  // R8
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(boot_rom));
  // R9
  copirq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (cop_irq == $past(reg_wdata[POS_COP_IRQ])));
  // R10
  busy_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[POS_DMA_BUSY] == cop_dma_busy) && (reg_rdata[POS_AUX_BUSY] == aux_dma_busy)
    && (reg_rdata[15:14] == 2'b00));
endmodule

bind cop_ctl_reg cop_ctl_reg_chk u_chk (.*);

// File: tb/cop_ctl_reg_bench.sv
`timescale 1ns/1ps
module cop_ctl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  evt_pulse = '0;
  logic        cop_dma_busy = 1'b0;
  logic        aux_dma_busy = 1'b0;
  logic        host_irq, cop_halt, cop_reset, boot_rom, cop_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int SP[4] = '{3, 5, 7, 12};

  logic [3:0] m_st, m_mk;
  logic       m_halt, m_ia, m_boot, m_rst;

  always #4 clk = ~clk;

  cop_ctl_reg u_cop_ctl_reg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .cop_dma_busy(cop_dma_busy),
    .aux_dma_busy(aux_dma_busy), .host_irq(host_irq), .cop_halt(cop_halt),
    .cop_reset(cop_reset), .boot_rom(boot_rom), .cop_irq(cop_irq)
  );

  function automatic logic [15:0] mkw(input logic [3:0] clr, input logic [3:0] msk,
                                      input logic h, input logic ia, input logic bt, input logic rs);
    logic [15:0] w = '0;
    w[0] = rs; w[1] = ia; w[2] = h; w[11] = bt;
    for (int i = 0; i < 4; i++) begin
      w[SP[i]]     = clr[i];
      w[SP[i] + 1] = msk[i];
    end
    return w;
  endfunction

  function automatic logic [15:0] exp_rd();
    logic [15:0] w = '0;
    w[1] = m_ia; w[2] = m_halt; w[11] = m_boot;
    w[9] = aux_dma_busy; w[10] = cop_dma_busy;
    for (int i = 0; i < 4; i++) begin
      w[SP[i]]     = m_st[i];
      w[SP[i] + 1] = m_mk[i];
    end
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "rdata", {16'h0, reg_rdata}, {16'h0, exp_rd()});
    chk(req, "host_irq", {31'h0, host_irq}, {31'h0, |(m_st & m_mk)});
    chk(req, "halt", {31'h0, cop_halt}, {31'h0, m_halt});
    chk(req, "cop_irq", {31'h0, cop_irq}, {31'h0, m_ia});
    chk(req, "boot_rom", {31'h0, boot_rom}, {31'h0, m_boot});
    chk(req, "cop_reset", {31'h0, cop_reset}, {31'h0, m_rst});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic w, input logic [15:0] d, input logic [3:0] e);
    reg_wr = w; reg_wdata = d; evt_pulse = e;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    for (int i = 0; i < 4; i++) begin
      if (e[i]) m_st[i] = 1'b1;
      else if (w && d[SP[i]]) m_st[i] = 1'b0;
      if (w) m_mk[i] = d[SP[i] + 1];
    end
    if (w) begin
      m_halt = d[2]; m_ia = d[1]; m_boot = d[11];
    end
    m_rst = w && d[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_st = '0; m_mk = '0; m_halt = 0; m_ia = 0; m_boot = 0; m_rst = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 R5 status x mask sweep
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 16; m++) begin
        cyc(1, mkw(4'hF, 4'h0, 0, 0, 0, 0), 4'h0);
        cyc(0, 16'h0, s[3:0]);
        check_all("R2");
        cyc(1, mkw(4'h0, m[3:0], 0, 0, 0, 0), 4'h0);
        check_all("R5");
      end
    end

    // R3 clear-pattern sweep (writing 0 keeps, writing 1 clears)
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        cyc(1, mkw(4'hF, 4'hF, 0, 0, 0, 0), 4'h0);
        cyc(0, 16'h0, s[3:0]);
        cyc(1, mkw(c[3:0], 4'hF, 0, 0, 0, 0), 4'h0);
        chk("R3", "status after w1c", {16'h0, reg_rdata},
            {16'h0, mkw(s[3:0] & ~c[3:0], 4'hF, 0, 0, 0, 0)});
        check_all("R3");
      end
    end

    // R4 event and clear in the same cycle
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        cyc(0, 16'h0, 4'hF);
        cyc(1, mkw(c[3:0], 4'h0, 0, 0, 0, 0), s[3:0]);
        chk("R4", "set wins", {16'h0, reg_rdata},
            {16'h0, mkw(~c[3:0] | s[3:0], 4'h0, 0, 0, 0, 0)});
        check_all("R4");
      end
    end

    // R6 R8 R9 level controls, each with an R7 reset request
    for (int k = 0; k < 8; k++) begin
      cyc(1, mkw(4'h0, 4'h5, k[0], k[1], k[2], 1), 4'h0);
      check_all("R7");
      chk("R7", "pulse high", {31'h0, cop_reset}, 32'h1);
      chk("R6", "halt", {31'h0, cop_halt}, {31'h0, k[0]});
      chk("R9", "cop_irq", {31'h0, cop_irq}, {31'h0, k[1]});
      chk("R8", "boot_rom", {31'h0, boot_rom}, {31'h0, k[2]});
      cyc(0, 16'h0, 4'h0);
      chk("R7", "pulse one cycle", {31'h0, cop_reset}, 32'h0);
      check_all("R8");
    end

    // R10 busy inputs and ignored bits
    for (int b = 0; b < 4; b++) begin
      cop_dma_busy = b[0]; aux_dma_busy = b[1];
      cyc(1, 16'hC600, 4'h0);
      chk("R10", "busy view", {16'h0, reg_rdata}, {16'h0, exp_rd()});
      chk("R10", "upper bits", {30'h0, reg_rdata[15:14]}, 32'h0);
      check_all("R10");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule